// File: doc/BRIEF.md
# Interrupt Line Capture Bank

This block captures up to 32 interrupt request lines and turns them into a vector of pending flags for a separate priority arbiter. Each line is set up by a sensitivity bit as either edge-triggered (a flag is raised once per inactive-to-active change of the input) or level-triggered (the flag follows an active input and drops when the input goes away). Raw inputs first pass through a synchronizer, so the block can accept requests from other clock domains.

Software can raise a line's flag through a trigger write. The trigger takes only the lowest set bit of the written word. Software clears flags through a write in which a 0 clears and a 1 keeps. The block refuses to clear a level line whose input is still active. When the arbiter reports that it has handed out a line's code, it signals this on an acknowledge port, and the block drops that line's flag if the line is edge-triggered. A mask register is held here and passed to the arbiter. Whenever a flag goes from clear to set, the block gives a one-cycle strobe that tells the arbiter to evaluate again.

Top module: `irq_capture_bank`

## Requirements
- R1: After reset, `pendingOut`, `senseOut` and `reevalOut` are all 0 and `maskOut` is all ones.
- R2: For an edge line (sense bit 0), a 0-to-1 change on `irqIn` sets its pending bit on the third rising clock edge after the change. An input that stays high does not set the bit again after it has been cleared.
- R3: For an edge line, the pending bit stays set when the input returns to 0.
- R4: For a level line (sense bit 1), an active input sets the pending bit with the same three-edge latency. When the input goes inactive, the bit clears with the same latency.
- R5: A pending write keeps the bits written as 1 and clears the bits written as 0. The exception is a level line whose synchronized input is active: its bit stays set.
- R6: When `ackValid` is high, the pending bit of line `ackLine` clears on the next edge if that line is edge-triggered. For a level line, the acknowledge has no effect.
- R7: A software trigger sets the pending bit of only the lowest-numbered set bit of `swTrigData`. For an edge line whose synchronized input is active, the trigger is ignored.
- R8: `reevalOut` is high for exactly the one cycle in which a pending bit has just changed from 0 to 1. It stays low when a set request hits a bit that is already pending.
- R9: When a set and a clear reach the same line on the same edge, the set wins and the line stays pending.
- R10: A mask write loads `maskOut` on the next edge and leaves the pending vector unchanged.
- R11: A sensitivity write loads `senseOut` on the next edge. The new mode governs the line from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 32 | Raw interrupt inputs, active high |
| senseWrEn | input | 1 | Load sensitivity register |
| senseWrData | input | 32 | Sensitivity value: 0 = edge, 1 = level |
| maskWrEn | input | 1 | Load mask register |
| maskWrData | input | 32 | Mask value |
| pendWrEn | input | 1 | Pending write (0 clears, 1 keeps) |
| pendWrData | input | 32 | Pending write data |
| swTrigEn | input | 1 | Software trigger request |
| swTrigData | input | 32 | Trigger word; only the lowest set bit acts |
| ackValid | input | 1 | Arbiter reports that a line's code was read |
| ackLine | input | 5 | Index of the acknowledged line |
| pendingOut | output | 32 | Pending vector to the arbiter |
| maskOut | output | 32 | Mask vector to the arbiter |
| senseOut | output | 32 | Current sensitivity bits |
| reevalOut | output | 1 | One-cycle re-evaluate strobe |

## Verification
The collision that matters is an acknowledge and a fresh input edge landing on the same line at the same clock edge. The bench first makes line 6 pending through a software trigger. It then raises the input of line 6 and times `ackValid` for line 6 so that it meets the rising edge exactly when that edge leaves the synchronizer. The scoreboard expects the line to remain pending and `reevalOut` to stay low, because the flag never went clear. A second overlap is a zero-write against a level line whose input is still held high, and there the bit must survive.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic senseWr;
    logic maskWr;
    logic pendWr;
    logic swTrig;
    logic ack;
  } bankStrobe_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl import irq_bank_pkg::*; #(
  parameter int NUM_LINES = 32,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 senseWrEn,
  input  logic                 maskWrEn,
  input  logic                 pendWrEn,
  input  logic                 swTrigEn,
  input  logic [NUM_LINES-1:0] swTrigData,
  input  logic                 ackValid,
  input  logic [LINE_W-1:0]    ackLine,
  input  logic [NUM_LINES-1:0] newBits,
  output bankStrobe_t          strb,
  output logic [NUM_LINES-1:0] swOneHot,
  output logic [NUM_LINES-1:0] ackOneHot,
  output logic                 reevalOut
);
  logic reevalQ;

  // Isolate the lowest set bit of the trigger word
  assign swOneHot = swTrigData & (-swTrigData);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_ackDecode
    assign ackOneHot[i] = ackValid && (ackLine == LINE_W'(i));
  end

  always_comb begin
    strb         = '0;
    strb.senseWr = senseWrEn;
    strb.maskWr  = maskWrEn;
    strb.pendWr  = pendWrEn;
    strb.swTrig  = swTrigEn && (|swTrigData);
    strb.ack     = ackValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reevalQ <= 1'b0;
    else       reevalQ <= |newBits;
  end

  assign reevalOut = reevalQ;

  // R7: a trigger selects exactly one line
  p_sw_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.swTrig |-> ($countones(swOneHot) == 1));

  // R6: acknowledge addresses at most one line
  p_ack_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackOneHot));
endmodule

// File: rtl/irq_bank_datapath.sv
module irq_bank_datapath import irq_bank_pkg::*; #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStrobe_t          strb,
  input  logic [NUM_LINES-1:0] syncIn,
  input  logic [NUM_LINES-1:0] swOneHot,
  input  logic [NUM_LINES-1:0] ackOneHot,
  input  logic [NUM_LINES-1:0] senseWrData,
  input  logic [NUM_LINES-1:0] maskWrData,
  input  logic [NUM_LINES-1:0] pendWrData,
  output logic [NUM_LINES-1:0] pendingOut,
  output logic [NUM_LINES-1:0] senseOut,
  output logic [NUM_LINES-1:0] maskOut,
  output logic [NUM_LINES-1:0] newBits
);
  logic [NUM_LINES-1:0] prevQ, pendQ, senseQ, maskQ;
  logic [NUM_LINES-1:0] riseVec, fallVec, hwSet, swSet, setVec;
  logic [NUM_LINES-1:0] levelClr, ackClr, wrClr, clrVec, pendNext;

  assign riseVec = syncIn & ~prevQ;
  assign fallVec = ~syncIn & prevQ;

  // Sources that raise a flag
  assign hwSet  = (~senseQ & riseVec) | (senseQ & syncIn);
  assign swSet  = {NUM_LINES{strb.swTrig}} & swOneHot & (senseQ | ~syncIn);
  assign setVec = hwSet | swSet;

  // Sources that drop a flag; level lines with an active input are shielded
  assign levelClr = senseQ & fallVec;
  assign ackClr   = {NUM_LINES{strb.ack}} & ackOneHot & ~senseQ;
  assign wrClr    = {NUM_LINES{strb.pendWr}} & ~pendWrData & ~(senseQ & syncIn);
  assign clrVec   = levelClr | ackClr | wrClr;

  // Set dominates clear
  assign pendNext = (pendQ & ~clrVec) | setVec;
  assign newBits  = pendNext & ~pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= '0;
      pendQ  <= '0;
      senseQ <= '0;
      maskQ  <= '1;
    end else begin
      prevQ <= syncIn;
      pendQ <= pendNext;
      if (strb.senseWr) senseQ <= senseWrData;
      if (strb.maskWr)  maskQ  <= maskWrData;
    end
  end

  assign pendingOut = pendQ;
  assign senseOut   = senseQ;
  assign maskOut    = maskQ;

  // R4: a falling level input leaves its line clear
  p_level_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((|(senseQ & fallVec)) && !strb.swTrig) |=>
      ((pendQ & $past(senseQ & fallVec)) == '0));

  // R5: a level line with active input survives a pending write
  p_write_guard_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.pendWr |=> ((($past(pendQ & senseQ & syncIn)) & ~pendQ) == '0));

  // R3: an edge line stays pending when its input falls, absent ack or write
  p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((|(pendQ & ~senseQ & fallVec)) && !strb.ack && !strb.pendWr) |=>
      ((pendQ & $past(pendQ & ~senseQ & fallVec)) == $past(pendQ & ~senseQ & fallVec)));

  // R10: a mask write leaves the pending vector alone
  p_mask_isolated_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskWr && !strb.pendWr && !strb.ack && !strb.swTrig && (syncIn == prevQ) && (senseQ == '0))
      |=> (pendQ == $past(pendQ)));
endmodule

// File: rtl/irq_capture_bank.sv
module irq_capture_bank import irq_bank_pkg::*; #(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LINE_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 senseWrEn,
  input  logic [NUM_LINES-1:0] senseWrData,
  input  logic                 maskWrEn,
  input  logic [NUM_LINES-1:0] maskWrData,
  input  logic                 pendWrEn,
  input  logic [NUM_LINES-1:0] pendWrData,
  input  logic                 swTrigEn,
  input  logic [NUM_LINES-1:0] swTrigData,
  input  logic                 ackValid,
  input  logic [LINE_W-1:0]    ackLine,
  output logic [NUM_LINES-1:0] pendingOut,
  output logic [NUM_LINES-1:0] maskOut,
  output logic [NUM_LINES-1:0] senseOut,
  output logic                 reevalOut
);
  bankStrobe_t          strb;
  logic [NUM_LINES-1:0] syncIn, swOneHot, ackOneHot, newBits;

  irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn(irqIn), .syncOut(syncIn));

  irq_bank_ctrl #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .senseWrEn(senseWrEn), .maskWrEn(maskWrEn), .pendWrEn(pendWrEn),
    .swTrigEn(swTrigEn), .swTrigData(swTrigData),
    .ackValid(ackValid), .ackLine(ackLine), .newBits(newBits),
    .strb(strb), .swOneHot(swOneHot), .ackOneHot(ackOneHot),
    .reevalOut(reevalOut));

  irq_bank_datapath #(.NUM_LINES(NUM_LINES)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .syncIn(syncIn),
    .swOneHot(swOneHot), .ackOneHot(ackOneHot),
    .senseWrData(senseWrData), .maskWrData(maskWrData), .pendWrData(pendWrData),
    .pendingOut(pendingOut), .senseOut(senseOut), .maskOut(maskOut),
    .newBits(newBits));

  // R8: the strobe marks exactly the cycles where a flag has just appeared
  p_reeval_on_new_r8: assert property (@(posedge clk) disable iff (!rstN)
    reevalOut == (|(pendingOut & ~$past(pendingOut))));
endmodule

// File: tb/test_irq_capture_bank.sv
module test_irq_capture_bank;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] irqIn, senseWrData, maskWrData, pendWrData, swTrigData;
  logic         senseWrEn, maskWrEn, pendWrEn, swTrigEn, ackValid;
  logic [4:0]   ackLine;
  logic [N-1:0] pendingOut, maskOut, senseOut;
  logic         reevalOut;

  always #2 clk = ~clk;

  irq_capture_bank i_irq_capture_bank (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .senseWrEn(senseWrEn), .senseWrData(senseWrData),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .pendWrEn(pendWrEn), .pendWrData(pendWrData),
    .swTrigEn(swTrigEn), .swTrigData(swTrigData),
    .ackValid(ackValid), .ackLine(ackLine),
    .pendingOut(pendingOut), .maskOut(maskOut), .senseOut(senseOut),
    .reevalOut(reevalOut));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int           at;
    logic [N-1:0] pend;
    bit           chkR;
    logic         reeval;
    string        tag;
  } exp_t;
  exp_t q[$];

  int nChecks = 0;
  int nFails  = 0;

  // Monitor: compare every expectation due in this cycle
  always @(negedge clk) begin
    for (int j = q.size() - 1; j >= 0; j--) begin
      if (q[j].at == cyc) begin
        nChecks++;
        if (pendingOut !== q[j].pend) begin
          nFails++;
          $display("FAIL %s: pendingOut=%h expected %h", q[j].tag, pendingOut, q[j].pend);
        end
        if (q[j].chkR) begin
          nChecks++;
          if (reevalOut !== q[j].reeval) begin
            nFails++;
            $display("FAIL %s: reevalOut=%b expected %b", q[j].tag, reevalOut, q[j].reeval);
          end
        end
        q.delete(j);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectAt(input int lat, input logic [N-1:0] p, input bit chkR,
                          input logic r, input string tag);
    exp_t e;
    e.at = cyc + lat; e.pend = p; e.chkR = chkR; e.reeval = r; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic checkVec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic swTrig(input logic [N-1:0] d, input logic [N-1:0] p, input logic r, input string tag);
    swTrigEn = 1'b1; swTrigData = d;
    expectAt(1, p, 1'b1, r, tag);
    tick(1); swTrigEn = 1'b0; tick(2);
  endtask

  task automatic pendWr(input logic [N-1:0] d, input logic [N-1:0] p, input string tag);
    pendWrEn = 1'b1; pendWrData = d;
    expectAt(1, p, 1'b1, 1'b0, tag);
    tick(1); pendWrEn = 1'b0; tick(2);
  endtask

  task automatic ackLn(input int ln, input logic [N-1:0] p, input string tag);
    ackValid = 1'b1; ackLine = 5'(ln);
    expectAt(1, p, 1'b1, 1'b0, tag);
    tick(1); ackValid = 1'b0; tick(2);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; irqIn = '0;
    senseWrEn = 0; maskWrEn = 0; pendWrEn = 0; swTrigEn = 0; ackValid = 0;
    senseWrData = '0; maskWrData = '0; pendWrData = '0; swTrigData = '0; ackLine = '0;
    tick(4); rstN = 1'b1; tick(1);

    checkVec("R1 pending reset", pendingOut, '0);
    checkVec("R1 sense reset", senseOut, '0);
    checkVec("R1 mask reset", maskOut, '1);
    checkVec("R1 reeval reset", {31'b0, reevalOut}, '0);

    // Edge line 3: rise, one-cycle strobe, hold after fall, ack
    irqIn[3] = 1'b1;
    expectAt(3, 32'h8, 1'b1, 1'b1, "R2 edge rise sets");
    expectAt(4, 32'h8, 1'b1, 1'b0, "R8 strobe lasts one cycle");
    tick(6);
    irqIn[3] = 1'b0;
    expectAt(3, 32'h8, 1'b1, 1'b0, "R3 edge flag held after fall");
    tick(5);
    ackLn(3, '0, "R6 ack clears edge line");

    // Edge line 5: held high input does not set again after ack
    irqIn[5] = 1'b1;
    expectAt(3, 32'h20, 1'b1, 1'b1, "R2 edge rise line 5");
    tick(5);
    ackValid = 1'b1; ackLine = 5'd5;
    expectAt(1, '0, 1'b1, 1'b0, "R6 ack line 5");
    expectAt(4, '0, 1'b1, 1'b0, "R2 steady high no retrigger");
    tick(1); ackValid = 1'b0; tick(5);
    irqIn[5] = 1'b0; tick(5);

    // Software trigger picks the lowest bit
    swTrig(32'h0C00, 32'h400, 1'b1, "R7 lowest set bit only");
    pendWr(~32'h400, '0, "R5 zero bit clears edge line");

    // Edge line with active input ignores software trigger
    irqIn[12] = 1'b1;
    expectAt(3, 32'h1000, 1'b1, 1'b1, "R2 edge rise line 12");
    tick(5);
    ackLn(12, '0, "R6 ack line 12");
    swTrig(32'h1000, '0, 1'b0, "R7 trigger ignored, edge input active");
    irqIn[12] = 1'b0; tick(5);

    // Collision: fresh edge and ack on already-pending line 6
    swTrig(32'h40, 32'h40, 1'b1, "R7 trigger sets line 6");
    irqIn[6] = 1'b1;
    tick(2);
    ackValid = 1'b1; ackLine = 5'd6;
    expectAt(1, 32'h40, 1'b1, 1'b0, "R9 set beats ack on same edge");
    tick(1); ackValid = 1'b0; tick(3);
    ackLn(6, '0, "R6 later ack clears line 6");
    irqIn[6] = 1'b0; tick(5);

    // Level line 8
    senseWrEn = 1'b1; senseWrData = 32'h100;
    tick(1); senseWrEn = 1'b0;
    checkVec("R11 sense loaded", senseOut, 32'h100);
    irqIn[8] = 1'b1;
    expectAt(3, 32'h100, 1'b1, 1'b1, "R4 level input sets");
    tick(5);
    pendWr('0, 32'h100, "R5 level line with active input protected");
    ackLn(8, 32'h100, "R6 ack ignored on level line");
    irqIn[8] = 1'b0;
    expectAt(3, '0, 1'b1, 1'b0, "R4 level clears on fall");
    tick(5);

    // Write-one retention and no strobe on repeat set
    swTrig(32'h1, 32'h1, 1'b1, "R7 trigger line 0");
    swTrig(32'h2, 32'h3, 1'b1, "R7 trigger line 1");
    pendWr(32'h2, 32'h2, "R5 one bits kept");
    swTrig(32'h2, 32'h2, 1'b0, "R8 no strobe when already pending");
    pendWr('0, '0, "R5 all zero clears");

    // Mask write
    maskWrEn = 1'b1; maskWrData = 32'h0F0F_0000;
    expectAt(1, '0, 1'b1, 1'b0, "R10 mask write leaves pending");
    tick(1); maskWrEn = 1'b0;
    checkVec("R10 mask loaded", maskOut, 32'h0F0F_0000);

    // Level line, inactive input: trigger sets, zero write clears
    swTrig(32'h100, 32'h100, 1'b1, "R7 trigger on idle level line");
    pendWr('0, '0, "R5 idle level line clears");

    tick(4);
    if (q.size() != 0) begin
      nFails++;
      $display("FAIL scoreboard: %0d expectations never compared, expected 0", q.size());
    end
    summary();
    $finish;
  end
endmodule